// File: doc/BRIEF.md
# Trigger-Controlled Up-Counter

This block is an up-counter with a programmable clock divider, a wrap limit, a compare channel and a slave controller. The slave controller decides how an external trigger line affects counting. Exactly one slave behaviour is in force at a time.

In free-run behaviour the trigger is ignored. In gated behaviour the counter advances only while the synchronised trigger is high. When the trigger drops, the counter holds its value and is not cleared. In restart behaviour each rising trigger edge clears the counter and divider, raises an update pulse, loads the pending divider value, and turns counting on.

The compare channel flips a level output each time counting lands on the compare value. Its output can therefore gate or restart a second instance. Software programs the block through a simple write port and may overwrite the counter at any time.

Top module: `tmr_slave_top`

## Requirements
- R1: After reset the counter output, the update pulse and the compare output are all 0, counting is off and the slave code is 4'b0000.
- R2: With counting on and slave code 4'b0000, the counter rises by one on every divider tick, and the trigger input has no effect.
- R3: On a tick where the counter equals or exceeds the wrap limit (address 2), the counter becomes 0 and the update output is 1 for that one cycle.
- R4: With slave code 4'b0101, the counter advances only while the synchronised trigger is high. While the trigger is low the counter keeps its value and is not cleared.
- R5: With slave code 4'b1000, a synchronised rising trigger edge clears the counter and the divider, pulses the update output, loads the pending divider value, and sets the counting enable bit.
- R6: The slave code is written to the control register (address 0) with its low three bits at data[2:0] and its top bit at data[16]. The enable bit sits at data[3]. Any code other than 4'b0101 or 4'b1000 acts as free-run.
- R7: A write to the counter (address 3) sets the counter from the next cycle and wins over counting in the same cycle. A restart from the trigger wins over that write.
- R8: The divider advances the counter once every PSC+1 enabled cycles. A value written to address 1 takes effect only at the next update event, which is a wrap or a restart.
- R9: The compare output flips whenever a count step, a wrap or a restart leaves the counter equal to the compare value (address 4). Software writes to the counter never flip it.
- R10: The trigger passes through a two-stage synchroniser, so a rising edge sampled at clock edge k restarts the counter at edge k+2.
- R11: With the enable bit clear, the counter holds its value in every slave code unless software writes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 divider, 2 wrap limit, 3 counter, 4 compare |
| wr_data | input | 32 | Register write data |
| trg_i | input | 1 | Asynchronous trigger input |
| cnt_o | output | 16 | Current counter value |
| upd_o | output | 1 | One-cycle update event pulse |
| cmp_o | output | 1 | Compare toggle output |

## Verification
The bench checks that a falling trigger in gated behaviour freezes the counter. A design that cleared the counter would return 0, and one that kept counting would keep rising. It selects restart behaviour through data bit 16 alone. A design that ignored that bit would never restart, and a wrong synchroniser depth would move the restart edge. It checks that a new divider value waits for a wrap, so a design that loaded it at once would change the step timing early. It also checks that counter writes beat counting while restarts beat writes, with the compare output held across software writes.

// File: rtl/tmr_slave_pkg.sv
package tmr_slave_pkg;

   typedef enum logic [3:0] {
      SLV_OFF     = 4'b0000,
      SLV_GATE    = 4'b0101,
      SLV_RESTART = 4'b1000
   } slv_code_e;

   typedef enum logic [1:0] {
      ACT_FREE,
      ACT_GATED,
      ACT_RESTART
   } slv_act_e;

   localparam logic [2:0] ADDR_CTRL = 3'd0;
   localparam logic [2:0] ADDR_PSC  = 3'd1;
   localparam logic [2:0] ADDR_WRAP = 3'd2;
   localparam logic [2:0] ADDR_CNT  = 3'd3;
   localparam logic [2:0] ADDR_CMP  = 3'd4;

   localparam int CTRL_EN_BIT  = 3;
   localparam int MODE_HI_BIT  = 16;

   // codes outside the two trigger behaviours fall back to free run
   function automatic slv_act_e decode_mode(input logic [3:0] code);
      case (code)
         SLV_GATE:    return ACT_GATED;
         SLV_RESTART: return ACT_RESTART;
         default:     return ACT_FREE;
      endcase
   endfunction

endpackage

// File: rtl/tmr_trig_sync.sv
module tmr_trig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic lvl,
   output logic rise
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("tmr_trig_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] stage_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         stage_q <= {stage_q[STAGES-2:0], d};
         prev_q  <= stage_q[STAGES-1];
      end
   end

   assign lvl  = stage_q[STAGES-1];
   assign rise = lvl & ~prev_q;

   // an edge indication never lasts two cycles
   p_rise_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         clear,
   input  logic [W-1:0] div,
   output logic         tick
);

   generate
      if (W < 1) begin : g_bad_width
         $error("tmr_prescale: W must be positive");
      end
   endgenerate

   logic [W-1:0] pc_q;

   assign tick = run && (pc_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pc_q <= '0;
      else if (clear)   pc_q <= '0;
      else if (run)     pc_q <= tick ? '0 : pc_q + 1'b1;
   end

   p_tick_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !clear) |=> (pc_q == '0));

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clear) |=> $stable(pc_q));

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         reinit,
   input  logic         sw_wr,
   input  logic [W-1:0] sw_val,
   input  logic         tick,
   input  logic [W-1:0] wrap,
   input  logic [W-1:0] cmp_val,
   output logic [W-1:0] cnt,
   output logic         upd,
   output logic         cmp_out,
   output logic         evt_now
);

   logic [W-1:0] cnt_q, nxt;
   logic         upd_q, cmp_q, adv;

   always_comb begin
      nxt     = cnt_q;
      evt_now = 1'b0;
      adv     = 1'b0;
      if (reinit) begin
         nxt     = '0;
         evt_now = 1'b1;
         adv     = 1'b1;
      end else if (sw_wr) begin
         nxt = sw_val;
      end else if (tick) begin
         adv = 1'b1;
         if (cnt_q >= wrap) begin
            nxt     = '0;
            evt_now = 1'b1;
         end else begin
            nxt = cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         upd_q <= 1'b0;
         cmp_q <= 1'b0;
      end else begin
         cnt_q <= nxt;
         upd_q <= evt_now;
         if (adv && (nxt == cmp_val)) cmp_q <= ~cmp_q;
      end
   end

   assign cnt     = cnt_q;
   assign upd     = upd_q;
   assign cmp_out = cmp_q;

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !reinit && !sw_wr && (cnt_q < wrap)) |=> (cnt_q == $past(cnt_q) + 1'b1));

   p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !reinit && !sw_wr && (cnt_q >= wrap)) |=> (cnt_q == '0 && upd_q));

   p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reinit |=> (cnt_q == '0 && upd_q));

   p_sw_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr && !reinit) |=> (cnt_q == $past(sw_val) && !upd_q));

   p_sw_no_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr && !reinit) |=> $stable(cmp_q));

endmodule

// File: rtl/tmr_slave_top.sv
module tmr_slave_top
   import tmr_slave_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PSC_W       = 16,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              trg_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              upd_o,
   output logic              cmp_o
);

   generate
      if (DATA_W <= MODE_HI_BIT) begin : g_bad_data
         $error("tmr_slave_top: DATA_W too narrow for the mode field");
      end
      if (CNT_W > DATA_W || PSC_W > DATA_W) begin : g_bad_fields
         $error("tmr_slave_top: field wider than write data");
      end
   endgenerate

   logic              en_q;
   logic [3:0]        mode_q;
   logic [PSC_W-1:0]  psc_pre_q, psc_act_q;
   logic [CNT_W-1:0]  wrap_q, cmp_q;
   logic              trg_lvl, trg_rise, tick, reinit, run, evt_now;
   slv_act_e          act;

   logic wr_ctrl, wr_psc, wr_wrap, wr_cnt, wr_cmp;
   assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
   assign wr_psc  = wr_en && (wr_addr == ADDR_PSC);
   assign wr_wrap = wr_en && (wr_addr == ADDR_WRAP);
   assign wr_cnt  = wr_en && (wr_addr == ADDR_CNT);
   assign wr_cmp  = wr_en && (wr_addr == ADDR_CMP);

   logic unused_data_bits;
   assign unused_data_bits = ^wr_data;

   tmr_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(trg_i), .lvl(trg_lvl), .rise(trg_rise));

   assign act    = decode_mode(mode_q);
   assign reinit = (act == ACT_RESTART) && trg_rise;
   assign run    = en_q && ((act != ACT_GATED) || trg_lvl);

   tmr_prescale #(.W(PSC_W)) u_psc (
      .clk(clk), .rst_n(rst_n), .run(run), .clear(reinit),
      .div(psc_act_q), .tick(tick));

   tmr_count_core #(.W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .reinit(reinit), .sw_wr(wr_cnt),
      .sw_val(wr_data[CNT_W-1:0]), .tick(tick), .wrap(wrap_q),
      .cmp_val(cmp_q), .cnt(cnt_o), .upd(upd_o), .cmp_out(cmp_o),
      .evt_now(evt_now));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         mode_q    <= SLV_OFF;
         psc_pre_q <= '0;
         psc_act_q <= '0;
         wrap_q    <= '1;
         cmp_q     <= '0;
      end else begin
         if (wr_ctrl) begin
            en_q   <= wr_data[CTRL_EN_BIT];
            mode_q <= {wr_data[MODE_HI_BIT], wr_data[2:0]};
         end
         if (reinit)  en_q      <= 1'b1;
         if (wr_psc)  psc_pre_q <= wr_data[PSC_W-1:0];
         if (wr_wrap) wrap_q    <= wr_data[CNT_W-1:0];
         if (wr_cmp)  cmp_q     <= wr_data[CNT_W-1:0];
         if (evt_now) psc_act_q <= psc_pre_q;
      end
   end

   p_gate_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((act == ACT_GATED) && !trg_lvl && !wr_cnt) |=> $stable(cnt_o));

   p_restart_enables_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reinit |=> en_q);

   p_stopped_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !reinit && !wr_cnt) |=> $stable(cnt_o));

   p_free_ignores_trg_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_FREE) |-> !reinit);

endmodule

// File: tb/tmr_slave_top_test.sv
module tmr_slave_top_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        trg_i = 1'b0;
   logic [15:0] cnt_o;
   logic        upd_o, cmp_o;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;   // 50 MHz

   tmr_slave_top uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .trg_i(trg_i), .cnt_o(cnt_o), .upd_o(upd_o),
      .cmp_o(cmp_o));

   task automatic check(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   // ---------------- reference model built from the requirements
   int unsigned m_s1, m_s2, m_s3, m_en, m_mode, m_pre, m_psc, m_wrap,
                m_cmpv, m_pc, m_cnt, m_upd, m_cmp;

   function automatic int mode_kind(input int unsigned code);
      if (code == 5) return 1;        // gated
      if (code == 8) return 2;        // restart
      return 0;                       // free run
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= 0; m_s2 <= 0; m_s3 <= 0; m_en <= 0; m_mode <= 0;
         m_pre <= 0; m_psc <= 0; m_wrap <= 16'hFFFF; m_cmpv <= 0;
         m_pc <= 0; m_cnt <= 0; m_upd <= 0; m_cmp <= 0;
      end else begin
         automatic int  k      = mode_kind(m_mode);
         automatic bit  rise   = (m_s2 == 1) && (m_s3 == 0);
         automatic bit  rst_ev = (k == 2) && rise;
         automatic bit  run    = (m_en == 1) && ((k != 1) || (m_s2 == 1));
         automatic bit  tk     = run && (m_pc == m_psc);
         automatic bit  wcnt   = wr_en && (wr_addr == 3);
         automatic int unsigned nc = m_cnt;
         automatic bit  ev = 0, adv = 0;
         m_s1 <= trg_i; m_s2 <= m_s1; m_s3 <= m_s2;
         if (rst_ev) begin
            nc = 0; ev = 1; adv = 1; m_pc <= 0;
         end else begin
            if (run) m_pc <= tk ? 0 : m_pc + 1;
            if (wcnt) nc = wr_data[15:0];
            else if (tk) begin
               adv = 1;
               if (m_cnt >= m_wrap) begin nc = 0; ev = 1; end
               else nc = m_cnt + 1;
            end
         end
         m_cnt <= nc;
         m_upd <= ev;
         if (adv && nc == m_cmpv) m_cmp <= m_cmp ^ 1;
         if (ev) m_psc <= m_pre;
         if (wr_en && wr_addr == 0) begin
            m_en   <= wr_data[3];
            m_mode <= {wr_data[16], wr_data[2:0]};
         end
         if (rst_ev) m_en <= 1;
         if (wr_en && wr_addr == 1) m_pre  <= wr_data[15:0];
         if (wr_en && wr_addr == 2) m_wrap <= wr_data[15:0];
         if (wr_en && wr_addr == 4) m_cmpv <= wr_data[15:0];
      end
   end

   // every cycle: outputs against the model
   always @(negedge clk) begin
      if (rst_n) begin
         case (mode_kind(m_mode))
            1:       check("R4 count (gated)", cnt_o, m_cnt);
            2:       check("R5 count (restart)", cnt_o, m_cnt);
            default: check("R2 count (free)", cnt_o, m_cnt);
         endcase
         check("R3 update pulse", upd_o, m_upd);
         check("R9 compare output", cmp_o, m_cmp);
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int v;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      // R1 reset state
      check("R1 cnt after reset", cnt_o, 0);
      check("R1 upd after reset", upd_o, 0);
      check("R1 cmp after reset", cmp_o, 0);

      // R8 divider change deferred to the update event
      wr(1, 32'd2);
      wr(2, 32'd2);
      wr(3, 32'd2);
      wr(0, 32'h0000_0008);         // enable, free run
      step();                       // old divider: tick, wrap
      check("R8 wrap with old divider cnt", cnt_o, 0);
      check("R8 wrap with old divider upd", upd_o, 1);
      step(); check("R8 hold under new divider", cnt_o, 0);
      step(); check("R8 hold under new divider", cnt_o, 0);
      step(); check("R8 step after PSC+1 cycles", cnt_o, 1);

      // R6 / R5 / R10 restart mode selected by data bit 16 alone
      wr(0, 32'h0000_0000);
      wr(1, 32'd0);
      wr(2, 32'd5);
      wr(0, 32'h0001_0000);         // code 1000, enable clear
      v = cnt_o;
      step(); step();
      check("R11 stopped before trigger", cnt_o, v);
      trg_i = 1'b1;
      step(); check("R10 no restart after one edge", upd_o, 0);
      step(); check("R10 no restart after two edges", upd_o, 0);
      step();
      check("R5 restart clears counter", cnt_o, 0);
      check("R10 restart at third edge", upd_o, 1);
      step();
      check("R5 counting started by restart", cnt_o, 1);
      check("R5 update is one cycle", upd_o, 0);

      // R7 restart beats a same-cycle counter write
      trg_i = 1'b0; step(); step(); step();
      trg_i = 1'b1; step();
      step();                       // rise visible before next edge
      wr(3, 32'd4);
      check("R7 restart wins over write", cnt_o, 0);

      // R4 gated hold without clearing
      wr(2, 32'd200);
      wr(3, 32'd0);
      wr(0, 32'h0000_000D);         // enable, code 0101
      repeat (10) step();
      trg_i = 1'b0;
      repeat (4) step();
      v = cnt_o;
      repeat (6) step();
      check("R4 gated value held", cnt_o, v);
      check("R4 held value not cleared", (v != 0) ? 1 : 0, 1);
      trg_i = 1'b1;
      repeat (5) step();
      check("R4 resumes when trigger high", (cnt_o > v) ? 1 : 0, 1);

      // R6 undefined code runs free, trigger ignored; R7 write wins over count
      wr(0, 32'h0000_000B);         // enable, code 0011
      wr(3, 32'd50);
      check("R7 write wins over counting", cnt_o, 50);
      trg_i = 1'b0; step();
      check("R6 undefined code counts", cnt_o, 51);
      trg_i = 1'b1; step();
      check("R2 trigger ignored", cnt_o, 52);

      // R11 enable clear freezes the counter
      wr(0, 32'h0000_0000);
      v = cnt_o;
      repeat (5) step();
      check("R11 disabled counter holds", cnt_o, v);

      // constrained random mix, compared against the model every cycle
      for (int i = 0; i < 6000; i++) begin
         if ($urandom_range(5) == 0) trg_i = ~trg_i;
         if ($urandom_range(7) == 0) begin
            int a = $urandom_range(4);
            logic [31:0] d;
            case (a)
               0: begin
                  int sel = $urandom_range(3);
                  d = '0;
                  d[3] = ($urandom_range(4) != 0);
                  case (sel)
                     0: d[2:0] = 3'b000;
                     1: d[2:0] = 3'b101;
                     2: d[16]  = 1'b1;
                     default: d[2:0] = 3'($urandom_range(7));
                  endcase
               end
               1: d = $urandom_range(3);
               2: d = $urandom_range(9);
               3: d = $urandom_range(12);
               default: d = $urandom_range(9);
            endcase
            wr(3'(a), d);
         end else begin
            step();
         end
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule